// File: doc/BRIEF.md
# Minimal 16-bit load/store processor core

This block is a small single-issue processor with separate code and data ports. Each cycle it presents a byte address on the code port and, one cycle later, receives the 16-bit instruction word stored there. The word is decoded and executed in that cycle. The core has sixteen 16-bit registers. Register 14 is the program counter and drives the code address, so any instruction that writes register 14 acts as a jump.

The data port has an address, write data, read data, a write strobe and a read strobe. A busy input lets a slow memory stretch an access. While an access waits, the core freezes: it fetches nothing new, commits nothing and raises no other strobe. The instruction set is small: no-op, set-immediate, load, store, add, compare and branch-if-equal. A single equal flag links compare to the branch.

Top module: `cpu16_core`

## Requirements
- R1: Reset is synchronous and active high. It clears every register and the equal flag. On the first cycle after reset the code address is 0x0000, and both strobes stay low until an instruction raises them.
- R2: The code address advances by 2 each cycle when there is no stall. The instruction word that arrives one cycle after its address was presented is the one executed, and the word present in the first cycle after reset is not executed.
- R3: The opcode is in bits 15:12: 0x0 no-op, 0x1 load, 0x2 store, 0x3 add, 0xC compare, 0xD branch-if-equal, 0xE set-immediate. Any other opcode behaves as a no-op.
- R4: Set-immediate (0xE) writes the zero-extended byte in bits 7:0 into the register selected by bits 11:8.
- R5: Add (0x3) writes, modulo 2^16, the sum of the registers selected by bits 7:4 and 3:0 into the register selected by bits 11:8.
- R6: Store (0x2) raises mem_we in its execute cycle. It drives mem_addr from the register in bits 7:4 and mem_wdata from the register in bits 11:8.
- R7: Load (0x1) raises mem_re with mem_addr taken from the register in bits 7:4. In the cycle the access completes (busy low), it captures mem_rdata into the register in bits 11:8.
- R8: While a strobe is high and mem_busy is high, the strobe, mem_addr, mem_wdata and code_addr all hold and no instruction completes. The access completes in the first cycle that mem_busy is low.
- R9: mem_busy has no effect in a cycle where no strobe is high.
- R10: Compare (0xC) sets the equal flag to whether the registers in bits 11:8 and 7:4 hold the same value. No other instruction changes the flag.
- R11: If the equal flag is set, branch-if-equal (0xD) makes the next code address equal to its own address + 2 + (sign-extended bits 7:0 shifted left by one). The word already fetched behind it is discarded. If the flag is clear the branch does nothing.
- R12: Writing register 14 makes the written value the next code address and discards the word already fetched behind the writing instruction. Reading register 14 gives the executing instruction's address + 2.
- R13: mem_we and mem_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| code_data | input | 16 | Instruction word for the address presented one cycle earlier |
| code_addr | output | 16 | Byte address of the instruction to fetch (register 14) |
| mem_rdata | input | 16 | Data read from memory, sampled when a load completes |
| mem_wdata | output | 16 | Data to be written by a store |
| mem_addr | output | 16 | Data memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_busy | input | 1 | Memory not ready; stalls a pending access |

## Verification
The assertions take for granted that mem_busy is a level that the memory may hold high for any number of cycles. They also assume that mem_rdata is valid in the cycle a read completes, and that the code port returns the addressed word exactly one cycle later. The bench's memory models keep to these assumptions. The code store is registered on code_addr, and the data memory answers reads combinationally and accepts a write only at an edge where busy is low. mem_busy is drawn at random every cycle, including cycles with no access, so stalls of varying length fall on loads, on stores and on idle cycles.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
    localparam int unsigned XLEN   = 16;
    localparam int unsigned ILEN   = 16;
    localparam int unsigned NREG   = 16;
    localparam int unsigned RIDX_W = $clog2(NREG);
    localparam int unsigned IMM_W  = 8;
    localparam int unsigned PC_IDX = 14;
    localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_CMP   = 4'hC,
        OP_BEQ   = 4'hD,
        OP_SET   = 4'hE
    } opcode_e;

    typedef struct packed {
        logic              is_set;
        logic              is_load;
        logic              is_store;
        logic              is_add;
        logic              is_cmp;
        logic              is_beq;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
    } decode_t;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] rf;
        logic                      eq;
        logic                      live;
        logic                      held;
        logic [ILEN-1:0]           ir;
    } core_state_t;
endpackage

// File: rtl/cpu16_decode.sv
`timescale 1ns/1ps
module cpu16_decode
    import cpu16_pkg::*;
(
    input  logic [ILEN-1:0] word,
    input  logic            live,
    output decode_t         dec
);
    localparam int unsigned OPC_LSB = ILEN - 4;

    always_comb begin
        dec     = '0;
        dec.rd  = word[OPC_LSB-1 -: RIDX_W];
        dec.ra  = word[OPC_LSB-RIDX_W-1 -: RIDX_W];
        dec.rb  = word[RIDX_W-1:0];
        dec.imm = word[IMM_W-1:0];
        if (live) begin
            case (opcode_e'(word[ILEN-1:OPC_LSB]))
                OP_SET:   dec.is_set   = 1'b1;
                OP_LOAD:  dec.is_load  = 1'b1;
                OP_STORE: dec.is_store = 1'b1;
                OP_ADD:   dec.is_add   = 1'b1;
                OP_CMP:   dec.is_cmp   = 1'b1;
                OP_BEQ:   dec.is_beq   = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/cpu16_exec.sv
`timescale 1ns/1ps
module cpu16_exec
    import cpu16_pkg::*;
(
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [XLEN-1:0]  seq_addr,
    input  logic [IMM_W-1:0] ofs,
    output logic [XLEN-1:0]  sum,
    output logic             same,
    output logic [XLEN-1:0]  br_target
);
    localparam int unsigned EXT_W = XLEN - IMM_W - 1;

    always_comb begin
        sum       = opa + opb;
        same      = (opa == opb);
        br_target = seq_addr + {{EXT_W{ofs[IMM_W-1]}}, ofs, 1'b0};
    end
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ILEN-1:0] code_data,
    output logic [XLEN-1:0] code_addr,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_wdata,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    input  logic            mem_busy
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);
    localparam int unsigned     ZPAD = XLEN - IMM_W;

    core_state_t       state_q, state_d;
    decode_t           dec;
    logic [ILEN-1:0]   cur_word;
    logic [XLEN-1:0]   val_d, val_a, val_b;
    logic [XLEN-1:0]   sum, br_target;
    logic              same;
    logic              stall;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [XLEN-1:0]   wr_val;

    // A stalled instruction is replayed from the hold register, since the
    // code port has already moved on to the word behind it.
    assign cur_word = state_q.held ? state_q.ir : code_data;

    cpu16_decode u_decode (
        .word (cur_word),
        .live (state_q.live),
        .dec  (dec)
    );

    assign val_d = state_q.rf[dec.rd];
    assign val_a = state_q.rf[dec.ra];
    assign val_b = state_q.rf[dec.rb];

    cpu16_exec u_exec (
        .opa       (val_a),
        .opb       (val_b),
        .seq_addr  (state_q.rf[PC_IDX]),
        .ofs       (dec.imm),
        .sum       (sum),
        .same      (same),
        .br_target (br_target)
    );

    assign stall = (dec.is_load | dec.is_store) & mem_busy;

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = dec.rd;
        wr_val = '0;
        if (dec.is_set) begin
            wr_en  = 1'b1;
            wr_val = {{ZPAD{1'b0}}, dec.imm};
        end else if (dec.is_add) begin
            wr_en  = 1'b1;
            wr_val = sum;
        end else if (dec.is_load) begin
            wr_en  = 1'b1;
            wr_val = mem_rdata;
        end
    end

    always_comb begin
        state_d = state_q;
        if (stall) begin
            state_d.held = 1'b1;
            state_d.ir   = cur_word;
        end else begin
            state_d.held           = 1'b0;
            state_d.live           = 1'b1;
            state_d.rf[PC_IDX]     = state_q.rf[PC_IDX] + STEP;
            if (wr_en) begin
                state_d.rf[wr_idx] = wr_val;
                if (wr_idx == PC_SEL) begin
                    state_d.live = 1'b0;
                end
            end
            if (dec.is_cmp) begin
                // compare uses rd and ra as its operands
                state_d.eq = (val_d == val_a);
            end
            if (dec.is_beq && state_q.eq) begin
                state_d.rf[PC_IDX] = br_target;
                state_d.live       = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q            <= '0;
            state_q.rf[PC_IDX] <= RESET_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    assign code_addr = state_q.rf[PC_IDX];
    assign mem_we    = dec.is_store;
    assign mem_re    = dec.is_load;
    assign mem_addr  = val_a;
    assign mem_wdata = val_d;
endmodule

// File: rtl/cpu16_core_chk.sv
`timescale 1ns/1ps
module cpu16_core_chk #(
    parameter logic [15:0] RESET_ADDR = '0
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic [15:0] code_addr
);
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (code_addr == RESET_ADDR && !mem_we && !mem_re));

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_busy) |=> (mem_we && $stable(mem_addr) &&
                                  $stable(mem_wdata) && $stable(code_addr)));

    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && mem_busy) |=> (mem_re && $stable(mem_addr) &&
                                  $stable(code_addr)));
endmodule

bind cpu16_core cpu16_core_chk #(.RESET_ADDR(RESET_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_busy  (mem_busy),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .code_addr (code_addr)
);

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_busy = 1'b0;
    logic [15:0] code_data = '0;
    logic [15:0] code_addr, mem_wdata, mem_addr;
    wire  [15:0] mem_rdata;
    logic        mem_we, mem_re;

    logic [15:0] rom [64];
    logic [15:0] dmem [256];
    logic [15:0] ref_mem [256];

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cpu16_core uut (
        .clk, .rst, .code_data, .code_addr, .mem_rdata,
        .mem_wdata, .mem_addr, .mem_we, .mem_re, .mem_busy
    );

    always @(posedge clk) code_data <= rom[code_addr[6:1]];
    always @(posedge clk) if (!rst && mem_we && !mem_busy) dmem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = dmem[mem_addr[7:0]];

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int a = 0; a < 64; a++) rom[a] = 16'h0000;
        for (int a = 0; a < 256; a++) begin
            dmem[a]    = 16'(a * 263 + 3);
            ref_mem[a] = 16'(a * 263 + 3);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mem_busy = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [15:0] gen_word(int i, int blen);
        logic [3:0] a, b, c, op;
        int k, s, u;
        a = 4'($urandom % 8);
        b = 4'($urandom % 8);
        c = 4'($urandom % 8);
        k = int'($urandom % 8);
        case (k)
            1: return {4'h3, a, b, c};
            2: return {4'hC, a, b, 4'h0};
            3: begin
                s = int'($urandom % 3);
                if (i + 1 + s > blen) s = blen - i - 1;
                return {4'hD, 4'h0, 8'(s)};
            end
            4: return {4'h1, a, b, 4'h0};
            5: return {4'h2, a, b, 4'h0};
            6: begin
                u = int'($urandom % 9);
                op = (u == 8) ? 4'hF : 4'(4 + u);
                return {op, 12'($urandom)};
            end
            default: return {4'hE, a, 8'($urandom)};
        endcase
    endfunction

    task automatic ref_run(input int halt_idx);
        logic [15:0] r [16];
        logic [15:0] w;
        bit eq;
        int i, nxt, steps, rd, ra, rb;
        for (int q = 0; q < 16; q++) r[q] = '0;
        eq = 1'b0;
        i = 0;
        steps = 0;
        while (i != halt_idx && steps < 2000) begin
            w = rom[i];
            rd = int'(w[11:8]);
            ra = int'(w[7:4]);
            rb = int'(w[3:0]);
            nxt = i + 1;
            case (w[15:12])
                4'h1: r[rd] = ref_mem[r[ra][7:0]];
                4'h2: ref_mem[r[ra][7:0]] = r[rd];
                4'h3: r[rd] = r[ra] + r[rb];
                4'hC: eq = (r[rd] == r[ra]);
                4'hD: if (eq) nxt = i + 1 + int'($signed(w[7:0]));
                4'hE: r[rd] = {8'h00, w[7:0]};
                default: ;
            endcase
            i = nxt;
            steps++;
        end
    endtask

    task automatic directed_a();
        clear_all();
        rom[0] = 16'hE125; rom[1] = 16'hE02A; rom[2] = 16'h2010; rom[3] = 16'h1210;
        rom[4] = 16'h3322; rom[5] = 16'h2310; rom[6] = 16'hC020; rom[7] = 16'hD001;
        rom[8] = 16'hE577; rom[9] = 16'hE430; rom[10] = 16'h2540; rom[11] = 16'hEE00;
        do_reset();
        // cycle 0
        check(code_addr == 16'h0000, "R1 reset fetch address", code_addr, 16'h0000);
        check(!mem_we && !mem_re, "R1 strobes low after reset", {14'h0, mem_we, mem_re}, 16'h0);
        tick(); // cycle 1
        check(code_addr == 16'h0002, "R2 fetch advance", code_addr, 16'h0002);
        mem_busy = 1'b1;
        tick(); // cycle 2
        check(code_addr == 16'h0004, "R9 busy without access ignored", code_addr, 16'h0004);
        mem_busy = 1'b0;
        tick(); // cycle 3: store
        check(mem_we && mem_addr == 16'h0025, "R6 store address", mem_addr, 16'h0025);
        check(mem_wdata == 16'h002A, "R4 R6 store data from set-immediate", mem_wdata, 16'h002A);
        mem_busy = 1'b1;
        tick(); // cycle 4: stalled store
        check(mem_we && code_addr == 16'h0006, "R8 store stall holds fetch", code_addr, 16'h0006);
        check(!mem_re, "R8 no new strobe while busy", {15'h0, mem_re}, 16'h0);
        mem_busy = 1'b0;
        tick(); // cycle 5: load
        check(code_addr == 16'h0008 && !mem_we, "R8 resume after busy low", code_addr, 16'h0008);
        check(mem_re && mem_addr == 16'h0025, "R7 load address", mem_addr, 16'h0025);
        check(dmem[8'h25] == 16'h002A, "R6 store written", dmem[8'h25], 16'h002A);
        mem_busy = 1'b1;
        tick(); // cycle 6: stalled load
        check(mem_re && code_addr == 16'h0008, "R8 load stall holds fetch", code_addr, 16'h0008);
        mem_busy = 1'b0;
        tick(); // cycle 7: add
        check(code_addr == 16'h000A, "R2 advance after stall", code_addr, 16'h000A);
        tick(); // cycle 8: store sum
        check(mem_we && mem_wdata == 16'h0054, "R5 R7 loaded value doubled", mem_wdata, 16'h0054);
        tick(); // cycle 9: compare
        tick(); // cycle 10: branch
        check(code_addr == 16'h0010, "R11 branch fetch address", code_addr, 16'h0010);
        tick(); // cycle 11
        check(code_addr == 16'h0012 && !mem_we && !mem_re, "R11 taken branch target", code_addr, 16'h0012);
        tick(); // cycle 12
        tick(); // cycle 13: store r5
        check(mem_we && mem_addr == 16'h0030, "R11 store after branch", mem_addr, 16'h0030);
        check(mem_wdata == 16'h0000, "R10 R11 skipped word not executed", mem_wdata, 16'h0000);
        tick(); // cycle 14: set pc
        tick(); // cycle 15
        check(code_addr == 16'h0000, "R12 write to r14 jumps", code_addr, 16'h0000);
        check(!mem_we && !mem_re, "R12 word behind jump discarded", {14'h0, mem_we, mem_re}, 16'h0);
    endtask

    task automatic directed_b();
        clear_all();
        rom[0] = 16'hE005; rom[1] = 16'hE106; rom[2] = 16'hC010; rom[3] = 16'hD002;
        rom[4] = 16'hE2F0; rom[5] = 16'h2020; rom[6] = 16'h33E0; rom[7] = 16'h2320;
        rom[8] = 16'hC000; rom[9] = 16'hD0FD;
        do_reset();
        repeat (6) tick(); // cycle 6: store r0
        check(mem_we && mem_addr == 16'h00F0 && code_addr == 16'h000C,
              "R10 R11 branch not taken on unequal", mem_addr, 16'h00F0);
        check(mem_wdata == 16'h0005, "R4 store data", mem_wdata, 16'h0005);
        tick(); tick(); // cycle 8
        check(mem_we && mem_wdata == 16'h0013, "R12 r14 reads address plus 2", mem_wdata, 16'h0013);
        tick(); tick(); tick(); // cycle 11
        check(code_addr == 16'h000E, "R11 backward branch", code_addr, 16'h000E);
        tick(); // cycle 12
        check(mem_we && mem_wdata == 16'h0013, "R11 branch target executed", mem_wdata, 16'h0013);
    endtask

    task automatic random_prog();
        int blen, halt_idx, hits, cycles, errs, first;
        blen = 30;
        clear_all();
        for (int i = 0; i < blen; i++) rom[i] = gen_word(i, blen);
        for (int k = 0; k < 8; k++) begin
            rom[blen + 2*k]     = {8'hEF, 8'(8'hF0 + k)};
            rom[blen + 2*k + 1] = {4'h2, 4'(k), 4'hF, 4'h0};
        end
        halt_idx = blen + 16;
        rom[halt_idx] = {8'hEE, 8'(2 * halt_idx)};
        ref_run(halt_idx);
        do_reset();
        hits = 0;
        cycles = 0;
        while (hits < 4 && cycles < 4000) begin
            mem_busy = (($urandom % 100) < 25);
            tick();
            cycles++;
            if (code_addr == 16'(2 * halt_idx)) hits++;
        end
        mem_busy = 1'b0;
        tick(); tick();
        check(hits >= 4, "R12 program reached its halt loop", 16'(hits), 16'd4);
        errs = 0;
        first = 0;
        for (int a = 0; a < 256; a++) begin
            if (dmem[a] !== ref_mem[a]) begin
                if (errs == 0) first = a;
                errs++;
            end
        end
        check(errs == 0, "R3 R4 R5 R6 R7 R8 R9 R10 R11 memory image", dmem[first], ref_mem[first]);
    endtask

    initial begin
        void'($urandom(32'd4242));
        directed_a();
        directed_b();
        for (int n = 0; n < 10; n++) random_prog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule